// File: doc/BRIEF.md
# Doorbell Interrupt Receiver

This block watches a stream of inbound memory writes and picks out the ones aimed at a programmed doorbell address. Each accepted write carries a vector number in its low data bits. The block records that vector as one of 32 pending interrupt bits and drives a single level interrupt line towards the host processor.

Software programs the block through a small word-indexed register port. It sets the 64-bit doorbell address and an enable bit, and it sets a data pattern with a per-bit compare mask. It reads which vectors are pending, acknowledges vectors by writing ones, and unmasks vectors, which all start masked. After servicing, it writes an end-of-interrupt strobe so the line drops for a cycle and can be seen rising again if work remains. The inbound side is a plain address/data strobe; packet decoding lives upstream.

Top module: `msi_rx_top`

## Requirements
- R1: After reset the pending bits are all zero, every vector is masked, the interrupt line is low and the address, high-address and match registers read zero.
- R2: An inbound write is accepted only when its 64-bit address equals {high register, low register bits 31:1, 0}; bit 0 of the low register is not part of the address, and a write to any other address changes nothing.
- R3: An accepted write must satisfy ((data[15:0] XOR match[15:0]) AND match[31:16]) == 0; it then sets pending bit data[4:0]. Data bits 31:16 are ignored. With match = 0xFFE06540, data 0x6540 to 0x655F select vectors 0 to 31.
- R4: When bit 0 of the low address register is 0, no inbound write sets any pending bit.
- R5: Register index 3 reads the pending bits, one per vector, bit n for vector n, masked or not.
- R6: Writing index 4 clears every pending bit whose data bit is 1; other bits keep their state.
- R7: Writing index 5 unmasks every vector whose data bit is 1; nothing masks a vector again. A masked vector stays pending but does not drive the interrupt line.
- R8: The interrupt line is high when any unmasked vector is pending, updated at the same clock edge that changes the pending or mask state.
- R9: Writing index 6 with data bit 0 set forces the interrupt line low for one cycle; on the next cycle it rises again if an unmasked vector is still pending.
- R10: When an inbound write sets a vector in the same cycle that index 4 clears it, the vector ends up pending.
- R11: Indices 0, 1 and 2 (low address, high address, match) read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx, combinational |
| in_valid | input | 1 | Inbound memory write strobe |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench walks a table of inbound writes that hit or miss by one address bit, by the enable bit placed in the address, by a wrong high word, or by a data bit inside the compare mask; a receiver that compares too few bits would raise vectors on these stray writes. It checks that a vector raised while masked is pending yet silent, and that the end-of-interrupt strobe produces exactly one low cycle before the line returns; a design that skips the drop would leave the line high with no edge to see. It also drives a raise and an acknowledge of the same vector in one cycle, where a design that lets the clear win would lose an interrupt.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned REG_W     = 32;

  localparam logic [REG_IDX_W-1:0] RIX_ADDR_LO = 3'd0;
  localparam logic [REG_IDX_W-1:0] RIX_ADDR_HI = 3'd1;
  localparam logic [REG_IDX_W-1:0] RIX_MATCH   = 3'd2;
  localparam logic [REG_IDX_W-1:0] RIX_RAISED  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RIX_CLEAR   = 3'd4;
  localparam logic [REG_IDX_W-1:0] RIX_UNMASK  = 3'd5;
  localparam logic [REG_IDX_W-1:0] RIX_EOI     = 3'd6;

  // Doorbell address: bit 0 of the low word is the enable, so it is
  // forced to zero in the compared address.
  function automatic logic [2*REG_W-1:0] doorbell_addr(
    input logic [REG_W-1:1] lo_hi_bits,
    input logic [REG_W-1:0] hi
  );
    return {hi, lo_hi_bits, 1'b0};
  endfunction

  // Upper half of the match word selects which data bits must equal the
  // lower half.
  function automatic logic data_hits(
    input logic [REG_W/2-1:0] data,
    input logic [REG_W-1:0]   match
  );
    return ((data ^ match[REG_W/2-1:0]) & match[REG_W-1:REG_W/2]) == '0;
  endfunction

endpackage

// File: rtl/msi_rx_regs.sv
module msi_rx_regs
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic [NUM_VEC-1:0]   pending,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [REG_W-1:0]     addr_lo,
  output logic [REG_W-1:0]     addr_hi,
  output logic [REG_W-1:0]     match_cfg,
  output logic [NUM_VEC-1:0]   clr_bits,
  output logic [NUM_VEC-1:0]   unmask_bits,
  output logic                 eoi_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo   <= '0;
      addr_hi   <= '0;
      match_cfg <= '0;
    end else if (reg_we) begin
      case (reg_idx)
        RIX_ADDR_LO: addr_lo   <= reg_wdata;
        RIX_ADDR_HI: addr_hi   <= reg_wdata;
        RIX_MATCH:   match_cfg <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Strobe-type registers: no storage, one-cycle action bits.
  assign clr_bits    = (reg_we && reg_idx == RIX_CLEAR)  ? reg_wdata[NUM_VEC-1:0] : '0;
  assign unmask_bits = (reg_we && reg_idx == RIX_UNMASK) ? reg_wdata[NUM_VEC-1:0] : '0;
  assign eoi_pulse   = reg_we && reg_idx == RIX_EOI && reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      RIX_ADDR_LO: reg_rdata = addr_lo;
      RIX_ADDR_HI: reg_rdata = addr_hi;
      RIX_MATCH:   reg_rdata = match_cfg;
      RIX_RAISED:  reg_rdata[NUM_VEC-1:0] = pending;
      default:     reg_rdata = '0;
    endcase
  end

  // A write to a storage index is visible on the read port next cycle.
  AST_REG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == RIX_MATCH) |=> (match_cfg == $past(reg_wdata))) // R11
    else $error("match register lost its write");

endmodule

// File: rtl/msi_rx_match.sv
module msi_rx_match
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               in_valid,
  input  logic [2*REG_W-1:0] in_addr,
  input  logic [REG_W-1:0]   in_data,
  input  logic [REG_W-1:0]   addr_lo,
  input  logic [REG_W-1:0]   addr_hi,
  input  logic [REG_W-1:0]   match_cfg,
  output logic               rx_enable,
  output logic               addr_ok,
  output logic               data_ok,
  output logic               hit,
  output logic [VEC_W-1:0]   hit_vec
);

  logic unused_data_hi;
  assign unused_data_hi = ^in_data[REG_W-1:REG_W/2];

  assign rx_enable = addr_lo[0];
  assign addr_ok   = in_addr == doorbell_addr(addr_lo[REG_W-1:1], addr_hi);
  assign data_ok   = data_hits(in_data[REG_W/2-1:0], match_cfg);
  assign hit       = in_valid && rx_enable && addr_ok && data_ok;
  assign hit_vec   = in_data[VEC_W-1:0];

endmodule

// File: rtl/msi_rx_pending.sv
module msi_rx_pending #(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [VEC_W-1:0]   hit_vec,
  input  logic [NUM_VEC-1:0] clr_bits,
  input  logic [NUM_VEC-1:0] unmask_bits,
  input  logic               eoi,
  output logic [NUM_VEC-1:0] pending_q,
  output logic [NUM_VEC-1:0] mask_q,
  output logic               irq_q
);

  logic [NUM_VEC-1:0] set_bits;
  logic [NUM_VEC-1:0] pend_d;
  logic [NUM_VEC-1:0] mask_d;
  logic               any_active_d;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    assign set_bits[i] = hit && (hit_vec == VEC_W'(i));
    // Set is ORed after the clear, so a same-cycle raise survives.
    assign pend_d[i]   = set_bits[i] | (pending_q[i] & ~clr_bits[i]);
    assign mask_d[i]   = mask_q[i] & ~unmask_bits[i];
  end

  assign any_active_d = |(pend_d & ~mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      mask_q    <= '1;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= pend_d;
      mask_q    <= mask_d;
      irq_q     <= !eoi && any_active_d;
    end
  end

  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending_q[$past(hit_vec)]) // R3
    else $error("hit did not raise its vector");

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0 && !hit) |=> ((pending_q & $past(clr_bits)) == '0)) // R6
    else $error("acknowledged vector still pending");

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_bits[hit_vec]) |=> pending_q[$past(hit_vec)]) // R10
    else $error("same-cycle clear beat the raise");

  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq_q) // R9
    else $error("line stayed high across end of interrupt");

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((pending_q & ~mask_q) != '0)) // R8
    else $error("line high with no unmasked pending vector");

  AST_MASK_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & ~$past(mask_q)) == '0)) // R7
    else $error("a vector became masked again");

endmodule

// File: rtl/msi_rx_top.sv
module msi_rx_top
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 in_valid,
  input  logic [2*REG_W-1:0]   in_addr,
  input  logic [REG_W-1:0]     in_data,
  output logic                 irq
);

  localparam int unsigned VEC_W = $clog2(NUM_VEC);

  logic [REG_W-1:0]   addr_lo;
  logic [REG_W-1:0]   addr_hi;
  logic [REG_W-1:0]   match_cfg;
  logic [NUM_VEC-1:0] clr_bits;
  logic [NUM_VEC-1:0] unmask_bits;
  logic               eoi_pulse;
  logic               rx_enable;
  logic               addr_ok;
  logic               data_ok;
  logic               hit;
  logic [VEC_W-1:0]   hit_vec;
  logic [NUM_VEC-1:0] pending_q;
  logic [NUM_VEC-1:0] mask_q;

  msi_rx_regs #(.NUM_VEC(NUM_VEC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .pending     (pending_q),
    .reg_rdata   (reg_rdata),
    .addr_lo     (addr_lo),
    .addr_hi     (addr_hi),
    .match_cfg   (match_cfg),
    .clr_bits    (clr_bits),
    .unmask_bits (unmask_bits),
    .eoi_pulse   (eoi_pulse)
  );

  msi_rx_match #(.NUM_VEC(NUM_VEC)) u_match (
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_data   (in_data),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .match_cfg (match_cfg),
    .rx_enable (rx_enable),
    .addr_ok   (addr_ok),
    .data_ok   (data_ok),
    .hit       (hit),
    .hit_vec   (hit_vec)
  );

  msi_rx_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .hit_vec     (hit_vec),
    .clr_bits    (clr_bits),
    .unmask_bits (unmask_bits),
    .eoi         (eoi_pulse),
    .pending_q   (pending_q),
    .mask_q      (mask_q),
    .irq_q       (irq)
  );

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> ((pending_q & ~$past(pending_q)) == '0)) // R4
    else $error("vector raised while reception disabled");

  AST_MISS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(addr_ok && data_ok)) |=> ((pending_q & ~$past(pending_q)) == '0)) // R2
    else $error("stray write raised a vector");

endmodule

// File: tb/msi_rx_top_bench.sv
module msi_rx_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_rx_top u_msi_rx_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .irq(irq)
  );

  localparam logic [63:0] DOOR = 64'h0000_000F_FFFF_FFFC;

  localparam logic [63:0] T_ADDR [0:8] = '{
    DOOR, DOOR, DOOR, DOOR + 64'd4, 64'h0000_0007_FFFF_FFFC,
    DOOR, DOOR, DOOR | 64'd1, DOOR };
  localparam logic [31:0] T_DATA [0:8] = '{
    32'h0000_6540, 32'h0000_655F, 32'h0000_6552, 32'h0000_6540, 32'h0000_6540,
    32'h0000_6440, 32'h0000_6560, 32'h0000_6545, 32'hABCD_6547 };

  // Expected pending set under match word 0xFFE06540: bits 15:5 must be 0x32A.
  function automatic logic [31:0] expect_bits(input logic [63:0] a, input logic [31:0] d);
    if (a == DOOR && d[15:5] == 11'h32A) return 32'd1 << d[4:0];
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] idx, output logic [31:0] val);
    reg_idx = idx;
    #1;
    val = reg_rdata;
  endtask

  task automatic inbound(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(3'd3, rd); chk("R1 raised after reset", rd, 0);
    reg_read(3'd0, rd); chk("R1 addr_lo after reset", rd, 0);
    reg_read(3'd2, rd); chk("R1 match after reset", rd, 0);
    chk("R1 irq after reset", irq, 0);

    // R11 programming and readback
    reg_write(3'd0, 32'hFFFF_FFFD);
    reg_write(3'd1, 32'h0000_000F);
    reg_write(3'd2, 32'hFFE0_6540);
    reg_read(3'd0, rd); chk("R11 addr_lo readback", rd, 32'hFFFF_FFFD);
    reg_read(3'd1, rd); chk("R11 addr_hi readback", rd, 32'h0000_000F);
    reg_read(3'd2, rd); chk("R11 match readback", rd, 32'hFFE0_6540);

    // R7 masked vector pending but silent, R1 all masked at reset
    inbound(DOOR, 32'h0000_6543);
    reg_read(3'd3, rd); chk("R7 masked vector pending", rd, 32'h8);
    chk("R7 masked vector keeps irq low", irq, 0);
    reg_write(3'd5, 32'hFFFF_FFFF);
    chk("R8 irq after unmask", irq, 1);
    reg_write(3'd4, 32'h8);
    reg_read(3'd3, rd); chk("R6 clear vector 3", rd, 0);
    chk("R8 irq falls with last clear", irq, 0);

    // R2 R3 R5 table walk
    for (int i = 0; i < 9; i++) begin
      logic [31:0] exp;
      exp = expect_bits(T_ADDR[i], T_DATA[i]);
      inbound(T_ADDR[i], T_DATA[i]);
      reg_read(3'd3, rd); chk($sformatf("R2/R3/R5 table entry %0d raised", i), rd, exp);
      chk($sformatf("R8 table entry %0d irq", i), irq, exp != 0);
      reg_write(3'd4, 32'hFFFF_FFFF);
      reg_read(3'd3, rd); chk($sformatf("R6 table entry %0d cleared", i), rd, 0);
    end

    // R4 reception disabled by bit 0 of the low address register
    reg_write(3'd0, 32'hFFFF_FFFC);
    inbound(DOOR, 32'h0000_6541);
    reg_read(3'd3, rd); chk("R4 disabled ignores write", rd, 0);
    chk("R4 disabled irq low", irq, 0);
    reg_write(3'd0, 32'hFFFF_FFFD);

    // R3 other match pattern: exact 16-bit compare, vector 0x14
    reg_write(3'd2, 32'hFFFF_1234);
    inbound(DOOR, 32'h0000_1235);
    reg_read(3'd3, rd); chk("R3 exact pattern mismatch", rd, 0);
    inbound(DOOR, 32'h0000_1234);
    reg_read(3'd3, rd); chk("R3 exact pattern vector 20", rd, 32'h0010_0000);
    reg_write(3'd4, 32'hFFFF_FFFF);
    reg_write(3'd2, 32'hFFE0_6540);

    // R9 end of interrupt: one low cycle, then back up
    inbound(DOOR, 32'h0000_6542);
    inbound(DOOR, 32'h0000_6545);
    chk("R8 irq with two pending", irq, 1);
    reg_write(3'd6, 32'h1);
    chk("R9 irq low after EOI", irq, 0);
    @(negedge clk);
    chk("R9 irq re-asserts after EOI", irq, 1);
    reg_write(3'd6, 32'h0);
    chk("R9 EOI write with bit0 clear has no effect", irq, 1);
    reg_write(3'd4, 32'h4);
    reg_read(3'd3, rd); chk("R6 partial clear keeps vector 5", rd, 32'h20);
    reg_write(3'd4, 32'h20);
    chk("R8 irq low when none pending", irq, 0);
    reg_write(3'd6, 32'h1);
    @(negedge clk);
    chk("R9 no re-assert when empty", irq, 0);

    // R10 raise and clear of the same vector in one cycle
    @(negedge clk);
    in_valid = 1'b1; in_addr = DOOR; in_data = 32'h0000_6549;
    reg_we = 1'b1; reg_idx = 3'd4; reg_wdata = 32'h0000_0200;
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
    reg_read(3'd3, rd); chk("R10 set wins over clear", rd, 32'h200);
    chk("R10 irq high", irq, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule